// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of a classic interval timer. Software writes a control byte at the control address, then writes a 16-bit reload value as two bytes at the data address, low byte first. The channel then counts down once per count-clock enable and drives a single output pin. In rate-generator mode the output is a short low pulse once per period. In square-wave mode the output is high for the first half of the period and low for the second half.

The control byte carries a channel selector, an access code, a mode code and a number-format bit. Only channel 0 is built, and counting is always binary. Control bytes aimed at other channels do nothing. A control byte with access code 00 is a latch command, which is outside this block, so it does nothing either.

Top module: `interval_timer_ch`

## Requirements
- R1: After reset the output is high, no count is running, the byte pointer expects a low byte, and the mode is rate generator. Count enables alone leave the output high.
- R2: A control byte (written with sel_ctrl=1) whose bits 7:6 are not 00 leaves the channel unchanged. A running count continues without disturbance.
- R3: A control byte with bits 7:6 = 00 and bits 5:4 = 00 is a latch command and has no effect. Any other access code arms a two-byte load at the data address (sel_ctrl=0): low byte first, high byte second.
- R4: An accepted control byte stops counting at once. It forces the output high, and the output stays high until both bytes of a new reload value have been written.
- R5: The counter loads the reload value on the first count enable strictly after the cycle in which the high byte was written. It then decrements once per enable.
- R6: Rate-generator mode (bits 3:1 not ending in 11, e.g. 010) gives a period of N enables. The output is low for exactly one enable, while the count equals 1, and is high again after the reload.
- R7: Square-wave mode (bits 2:1 = 11, i.e. mode codes 011 and 111) gives a period of N enables. The output is high for the first ceil(N/2) enables and low for the remaining floor(N/2).
- R8: A reload value of 0 counts as 65536 enables.
- R9: When an accepted control byte and a count enable fall in the same cycle, the control byte wins. The output is high afterwards and the count does not advance.
- R10: Bit 0 (number format) is ignored. Counting is always binary, so a reload of 0x0010 gives a period of 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| sel_ctrl | input | 1 | 1 selects the control address, 0 the data address |
| wr_data | input | 8 | Write data byte |
| cnt_en | input | 1 | Count-clock enable, one decrement per asserted cycle |
| wave_out | output | 1 | Timer output |

## Verification
Two events can fall in the same clock cycle, and both are provoked on purpose. First, the high-byte write is issued with cnt_en asserted. The output must still be high two enables later, which shows that the load waited for a later enable. Second, a control byte is written in the same cycle as an enable, just before the count would reach 1. The output must stay high through further enables, which shows that stopping takes priority over decrementing.

// File: rtl/itm_pkg.sv
package itm_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SPAN_W = 33;

  typedef enum logic {
    WAVE_RATE   = 1'b0,
    WAVE_SQUARE = 1'b1
  } wave_e;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] access;
    logic [2:0] mode;
    logic       fmt;
  } ctl_word_t;

  function automatic ctl_word_t split_ctl(input logic [BYTE_W-1:0] w);
    ctl_word_t c;
    c.chan   = w[7:6];
    c.access = w[5:4];
    c.mode   = w[3:1];
    c.fmt    = w[0];
    return c;
  endfunction

  function automatic wave_e wave_of(input logic [2:0] m);
    return (m[1:0] == 2'b11) ? WAVE_SQUARE : WAVE_RATE;
  endfunction

  // effective length of a count value: zero stands for the full range
  function automatic logic [SPAN_W-1:0] span_of(input logic [31:0] v,
                                                input int unsigned w);
    logic [SPAN_W-1:0] r;
    if (v == 32'd0) r = SPAN_W'(1) << w;
    else            r = {1'b0, v};
    return r;
  endfunction

  function automatic logic square_high(input logic [SPAN_W-1:0] cur,
                                       input logic [SPAN_W-1:0] per);
    return cur > (per >> 1);
  endfunction

endpackage

// File: rtl/itm_cfg_decode.sv
module itm_cfg_decode
  import itm_pkg::*;
#(
  parameter int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              arm_o,
  output logic              commit_o,
  output wave_e             wave_o,
  output logic [CNT_W-1:0]  reload_o
);

  localparam int unsigned HALF_W = CNT_W / 2;

  ctl_word_t          cw;
  logic               ctl_wr;
  logic               dat_wr;
  logic               ptr_hi_q;
  wave_e              wave_q;
  logic [HALF_W-1:0]  lo_q;
  logic [HALF_W-1:0]  hi_q;

  assign cw     = split_ctl(wr_data);
  assign ctl_wr = wr_en && sel_ctrl;
  assign dat_wr = wr_en && !sel_ctrl;

  // accepted control word: channel 0 and not a latch command
  assign arm_o    = ctl_wr && (cw.chan == 2'b00) && (cw.access != 2'b00);
  assign commit_o = dat_wr && ptr_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_hi_q <= 1'b0;
      wave_q   <= WAVE_RATE;
      lo_q     <= '0;
      hi_q     <= '0;
    end else if (arm_o) begin
      ptr_hi_q <= 1'b0;
      wave_q   <= wave_of(cw.mode);
    end else if (dat_wr) begin
      ptr_hi_q <= !ptr_hi_q;
      if (ptr_hi_q) hi_q <= HALF_W'(wr_data);
      else          lo_q <= HALF_W'(wr_data);
    end
  end

  assign wave_o   = wave_q;
  assign reload_o = {hi_q, lo_q};

  AST_FOREIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (wr_data[7:6] != 2'b00)) |=> ($stable(wave_q) && $stable(ptr_hi_q))) // R2
    else $error("foreign control word changed channel state");

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (wr_data[7:4] == 4'b0000)) |=> ($stable(wave_q) && $stable(ptr_hi_q))) // R3
    else $error("latch command changed channel state");

endmodule

// File: rtl/itm_down_count.sv
module itm_down_count
  import itm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             arm,
  input  logic             commit,
  input  logic [CNT_W-1:0] reload_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic             running_o,
  output logic             load_fire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic             running_q;
  logic             pend_q;
  logic             at_one;
  logic             step;

  assign at_one      = (cnt_q == CNT_W'(1));
  assign load_fire_o = cnt_en && pend_q && !arm;
  assign step        = cnt_en && running_q && !arm && !load_fire_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      period_q  <= '0;
      running_q <= 1'b0;
      pend_q    <= 1'b0;
    end else if (arm) begin
      running_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (load_fire_o) begin
        cnt_q     <= reload_in;
        period_q  <= reload_in;
        running_q <= 1'b1;
      end else if (step) begin
        cnt_q <= at_one ? period_q : cnt_q - CNT_W'(1);
      end
      if (commit)           pend_q <= 1'b1;
      else if (load_fire_o) pend_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign period_o  = period_q;
  assign running_o = running_q;

  AST_LOAD_TAKES_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire_o |=> (running_q && (cnt_q == $past(reload_in)))) // R5
    else $error("load did not take the reload value");

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_one) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))) // R5
    else $error("counter did not decrement by one");

  AST_NO_LOAD_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pend_q && !arm) |=> (pend_q && $stable(running_q))) // R5
    else $error("high-byte write loaded in its own cycle");

endmodule

// File: rtl/itm_wave_gen.sv
module itm_wave_gen
  import itm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             running,
  input  wave_e            wave,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  output logic             out_o
);

  logic [SPAN_W-1:0] cur_span;
  logic [SPAN_W-1:0] per_span;
  logic              rate_level;
  logic              square_level;

  assign cur_span     = span_of(32'(cnt), CNT_W);
  assign per_span     = span_of(32'(period), CNT_W);
  assign rate_level   = (cnt != CNT_W'(1));
  assign square_level = square_high(cur_span, per_span);

  always_comb begin
    if (!running)                out_o = 1'b1;
    else if (wave == WAVE_RATE)  out_o = rate_level;
    else                         out_o = square_level;
  end

endmodule

// File: rtl/interval_timer_ch.sv
module interval_timer_ch
  import itm_pkg::*;
#(
  parameter int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cnt_en,
  output logic              wave_out
);

  logic             arm;
  logic             commit;
  wave_e            wave;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic             running;
  logic             load_fire;

  itm_cfg_decode #(.CNT_W(CNT_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel_ctrl (sel_ctrl),
    .wr_data  (wr_data),
    .arm_o    (arm),
    .commit_o (commit),
    .wave_o   (wave),
    .reload_o (reload)
  );

  itm_down_count #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .arm         (arm),
    .commit      (commit),
    .reload_in   (reload),
    .cnt_o       (cnt),
    .period_o    (period),
    .running_o   (running),
    .load_fire_o (load_fire)
  );

  itm_wave_gen #(.CNT_W(CNT_W)) u_wave (
    .running (running),
    .wave    (wave),
    .cnt     (cnt),
    .period  (period),
    .out_o   (wave_out)
  );

  AST_ARM_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> wave_out) // R4
    else $error("output not high after control word");

  AST_ARM_BEATS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && cnt_en) |=> (!running && $stable(cnt))) // R9
    else $error("count advanced in a control-word cycle");

  AST_RATE_LOW_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (wave == WAVE_RATE) && !wave_out && cnt_en && !arm && !load_fire
     && (period != CNT_W'(1))) |=> wave_out) // R6
    else $error("rate pulse longer than one enable");

endmodule

// File: tb/interval_timer_ch_test.sv
module interval_timer_ch_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       sel_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cnt_en = 1'b0;
  logic       wave_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  interval_timer_ch uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel_ctrl (sel_ctrl),
    .wr_data  (wr_data),
    .cnt_en   (cnt_en),
    .wave_out (wave_out)
  );

  // {control, reload, expected high enables, expected low enables}
  localparam int NV = 7;
  localparam logic [55:0] VEC [NV] = '{
    {8'h34, 16'd5,   16'd4,   16'd1},
    {8'h34, 16'd2,   16'd1,   16'd1},
    {8'h34, 16'd259, 16'd258, 16'd1},
    {8'h35, 16'h0010, 16'd15, 16'd1},
    {8'h36, 16'd6,   16'd3,   16'd3},
    {8'h36, 16'd7,   16'd4,   16'd3},
    {8'h3E, 16'd4,   16'd2,   16'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic [7:0] d);
    wr_en = 1'b1; sel_ctrl = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic program_ch(input logic [7:0] ctl, input logic [15:0] rl);
    wr(1'b1, ctl);
    wr(1'b0, rl[7:0]);
    wr(1'b0, rl[15:8]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", int'(wave_out), 1);
    lows = 0;
    for (int k = 0; k < 4; k++) begin tick(); if (!wave_out) lows++; end
    check("R1 enables without setup", lows, 0);

    // table of periods
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  ctl;
      logic [15:0] rl;
      int n, nh, nl;
      string tag;
      ctl = VEC[i][55:48];
      rl  = VEC[i][47:32];
      tag = ctl[0] ? "R10" : ((ctl[2:1] == 2'b11) ? "R7" : "R6");
      n = int'(rl);
      program_ch(ctl, rl);
      tick();
      nh = 0; nl = 0;
      for (int k = 0; k < n; k++) begin
        if (wave_out) nh++; else nl++;
        if (k != n - 1) tick();
      end
      check({tag, " high enables"}, nh, int'(VEC[i][31:16]));
      check({tag, " low enables"}, nl, int'(VEC[i][15:0]));
      tick();
      check({tag, " high after reload"}, int'(wave_out), 1);
    end

    // reload of zero = full range
    begin
      int nl, lowidx;
      program_ch(8'h34, 16'h0000);
      tick();
      nl = 0; lowidx = -1;
      for (int k = 0; k < 65536; k++) begin
        if (!wave_out) begin nl++; lowidx = k; end
        if (k != 65535) tick();
      end
      check("R8 low count in full range", nl, 1);
      check("R8 low position", lowidx, 65535);
      tick();
      check("R8 high after reload", int'(wave_out), 1);
    end

    // foreign channel control word does not disturb
    program_ch(8'h34, 16'd4);
    tick(); tick(); tick();
    wr(1'b1, 8'h74);
    check("R2 output after foreign word", int'(wave_out), 1);
    tick();
    check("R2 count continued", int'(wave_out), 0);

    // latch command ignored
    program_ch(8'h34, 16'd4);
    tick(); tick(); tick();
    wr(1'b1, 8'h04);
    tick();
    check("R3 latch command ignored", int'(wave_out), 0);

    // control word stops, needs both bytes
    program_ch(8'h34, 16'd4);
    tick(); tick(); tick();
    wr(1'b1, 8'h34);
    check("R4 high after control", int'(wave_out), 1);
    lows = 0;
    for (int k = 0; k < 6; k++) begin tick(); if (!wave_out) lows++; end
    check("R4 stopped after control", lows, 0);
    wr(1'b0, 8'd3);
    lows = 0;
    for (int k = 0; k < 5; k++) begin tick(); if (!wave_out) lows++; end
    check("R4 low byte alone does not start", lows, 0);
    wr(1'b0, 8'd0);
    tick();
    check("R5 loaded count high", int'(wave_out), 1);
    tick();
    check("R5 second count high", int'(wave_out), 1);
    tick();
    check("R5 reaches one", int'(wave_out), 0);

    // high-byte write coinciding with an enable
    wr(1'b1, 8'h34);
    wr(1'b0, 8'd2);
    wr_en = 1'b1; sel_ctrl = 1'b0; wr_data = 8'd0; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
    check("R5 same-cycle commit", int'(wave_out), 1);
    tick();
    check("R5 deferred load high", int'(wave_out), 1);
    tick();
    check("R6 pulse after deferred load", int'(wave_out), 0);

    // control word coinciding with an enable
    program_ch(8'h34, 16'd3);
    tick(); tick();
    wr_en = 1'b1; sel_ctrl = 1'b1; wr_data = 8'h34; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
    check("R9 control wins over enable", int'(wave_out), 1);
    tick();
    check("R9 stays stopped", int'(wave_out), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule